// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the register file that sits between a processor bus and the sequencers of a multi-channel DMA engine. Software programs each channel through a group of four word registers and a separate pitch word. The bank presents all of these to the sequencers as flat output vectors. Writing a channel's address word launches that channel with a one-cycle start strobe. A separate write-only word stops any set of channels with a one-cycle stop strobe.

The sequencers report the end of a transfer with a per-channel completion pulse. The bank latches each pulse into a pending-status word, which software clears by writing ones. A single interrupt line is raised whenever any pending bit is also enabled. The enable word and the loop-control word can be written directly, and each also has a clear alias, so one channel's bits can be dropped without a read-modify-write sequence. Looping on channel n needs two bits of the loop word, bit n and bit n+16, to be set together.

Top module: `dma_regbank`

## Requirements
- R1: After reset, every register reads zero, and irq, ch_start, ch_stop and loop_en are all low.
- R2: Channel c owns byte offsets c*0x10 + {0x0 address, 0x4 line length, 0x8 line count, 0xC control}. Each is a 32-bit read/write word and drives slot c (bits c*32 upward) of ch_addr, ch_xlen, ch_ylen and ch_ctrl.
- R3: The pitch word of channel c is at 0x100 + 4*c. It reads back as written and drives slot c of ch_pitch.
- R4: A write to channel c's address word raises ch_start[c], and only that bit, for exactly the one cycle after the write edge, while the new address is already on ch_addr. Writes to the channel's other words raise no start.
- R5: A write to offset 0x140 drives ch_stop with wdata bits [NCH-1:0] for exactly the one cycle after the write edge. At all other times ch_stop is zero, and a read of 0x140 returns zero.
- R6: A done_evt[n] pulse sets bit n of the status word at 0x144. Writing a one to a status bit clears it, and zero bits leave the status unchanged.
- R7: If done_evt[n] arrives in the same cycle as a write that clears status bit n, the bit stays set.
- R8: The enable word at 0x148 is read/write. Ones written to 0x14C clear the matching enable bits and leave the others as they are. A read of 0x14C returns zero.
- R9: irq is high exactly when some channel has both its status bit and its enable bit set. It rises in the cycle after the edge that captures the completion.
- R10: The loop word at 0x150 is read/write. loop_en[n] is high only when both bit n and bit n+16 are set. Ones written to 0x15C clear the matching loop bits, and a read of 0x15C returns zero.
- R11: Reads of unmapped or misaligned offsets (low two bits nonzero) return zero, and writes to them change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current addr/wdata |
| addr | input | AW | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| done_evt | input | NCH | Per-channel completion pulses from the sequencers |
| irq | output | 1 | Combined interrupt request |
| ch_addr | output | NCH*32 | Address word of each channel |
| ch_xlen | output | NCH*32 | Line length word of each channel |
| ch_ylen | output | NCH*32 | Line count word of each channel |
| ch_ctrl | output | NCH*32 | Control word of each channel |
| ch_pitch | output | NCH*32 | Pitch word of each channel |
| ch_start | output | NCH | One-cycle start strobes |
| ch_stop | output | NCH | One-cycle stop strobes |
| loop_en | output | NCH | Per-channel loop enable |

## Verification
The assertions assume that every address is stable for the whole cycle in which wr_en is high, and that done_evt carries only single-cycle pulses timed to the clock. The bench meets both: it changes wr_en, addr, wdata and done_evt only on falling edges and holds each pulse for one full period. The collision rule is the one case where stimulus deliberately lines a completion up with a clearing write on the same edge. The bench also keeps the enable mask zero for the events whose effect on irq must stay hidden.

// File: rtl/dma_regbank.sv
module dma_regbank #(
  parameter int NCH = 16,
  parameter int AW  = 12,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [NCH-1:0]    done_evt,
  output logic              irq,
  output logic [NCH*DW-1:0] ch_addr,
  output logic [NCH*DW-1:0] ch_xlen,
  output logic [NCH*DW-1:0] ch_ylen,
  output logic [NCH*DW-1:0] ch_ctrl,
  output logic [NCH*DW-1:0] ch_pitch,
  output logic [NCH-1:0]    ch_start,
  output logic [NCH-1:0]    ch_stop,
  output logic [NCH-1:0]    loop_en
);
  localparam int CIW     = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int GRP     = 16;
  localparam int LOOP_HI = 16;
  localparam logic [AW-1:0] A_PITCH  = AW'(12'h100);
  localparam logic [AW-1:0] A_STOP   = AW'(12'h140);
  localparam logic [AW-1:0] A_STS    = AW'(12'h144);
  localparam logic [AW-1:0] A_IEN    = AW'(12'h148);
  localparam logic [AW-1:0] A_IENCLR = AW'(12'h14C);
  localparam logic [AW-1:0] A_LOOP   = AW'(12'h150);
  localparam logic [AW-1:0] A_LPCLR  = AW'(12'h15C);
  localparam logic [DW-1:0] CH_ONES  = DW'((64'd1 << NCH) - 64'd1);
  localparam logic [DW-1:0] LP_MASK  = CH_ONES | (CH_ONES << LOOP_HI);

  logic [NCH-1:0] ist_q, ien_q, stop_q, start_q;
  logic [DW-1:0]  lp_q;

  logic           aligned, in_grp, in_pitch;
  logic [CIW-1:0] gch, pch;
  logic [1:0]     fld;

  assign aligned  = (addr[1:0] == 2'b00);
  assign in_grp   = aligned && (int'(addr) < NCH * GRP);
  assign in_pitch = aligned && (addr >= A_PITCH) && (int'(addr) < int'(A_PITCH) + 4 * NCH);
  assign gch      = addr[CIW+3:4];
  assign pch      = addr[CIW+1:2];
  assign fld      = addr[3:2];

  logic wr_stop, wr_sts, wr_ien, wr_ienclr, wr_loop, wr_lpclr;
  assign wr_stop   = wr_en && (addr == A_STOP);
  assign wr_sts    = wr_en && (addr == A_STS);
  assign wr_ien    = wr_en && (addr == A_IEN);
  assign wr_ienclr = wr_en && (addr == A_IENCLR);
  assign wr_loop   = wr_en && (addr == A_LOOP);
  assign wr_lpclr  = wr_en && (addr == A_LPCLR);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0] a_q, x_q, y_q, k_q, p_q;
    logic          sel;
    assign sel = wr_en && in_grp && (gch == CIW'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q <= '0;
        x_q <= '0;
        y_q <= '0;
        k_q <= '0;
        start_q[c] <= 1'b0;
      end else begin
        start_q[c] <= sel && (fld == 2'd0);
        if (sel) begin
          case (fld)
            2'd0:    a_q <= wdata;
            2'd1:    x_q <= wdata;
            2'd2:    y_q <= wdata;
            default: k_q <= wdata;
          endcase
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        p_q <= '0;
      else if (wr_en && in_pitch && (pch == CIW'(c)))
        p_q <= wdata;
    end

    assign ch_addr [c*DW +: DW] = a_q;
    assign ch_xlen [c*DW +: DW] = x_q;
    assign ch_ylen [c*DW +: DW] = y_q;
    assign ch_ctrl [c*DW +: DW] = k_q;
    assign ch_pitch[c*DW +: DW] = p_q;
    assign loop_en[c] = lp_q[c] & lp_q[c+LOOP_HI];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ist_q  <= '0;
      ien_q  <= '0;
      lp_q   <= '0;
      stop_q <= '0;
    end else begin
      stop_q <= wr_stop ? wdata[NCH-1:0] : '0;
      ist_q  <= (ist_q & ~(wr_sts ? wdata[NCH-1:0] : '0)) | done_evt;
      if (wr_ien)
        ien_q <= wdata[NCH-1:0];
      else if (wr_ienclr)
        ien_q <= ien_q & ~wdata[NCH-1:0];
      if (wr_loop)
        lp_q <= wdata & LP_MASK;
      else if (wr_lpclr)
        lp_q <= lp_q & ~wdata;
    end
  end

  assign ch_start = start_q;
  assign ch_stop  = stop_q;
  assign irq      = |(ist_q & ien_q);

  always_comb begin
    rdata = '0;
    if (in_grp) begin
      case (fld)
        2'd0:    rdata = ch_addr[gch*DW +: DW];
        2'd1:    rdata = ch_xlen[gch*DW +: DW];
        2'd2:    rdata = ch_ylen[gch*DW +: DW];
        default: rdata = ch_ctrl[gch*DW +: DW];
      endcase
    end else if (in_pitch) begin
      rdata = ch_pitch[pch*DW +: DW];
    end else if (addr == A_STS) begin
      rdata[NCH-1:0] = ist_q;
    end else if (addr == A_IEN) begin
      rdata[NCH-1:0] = ien_q;
    end else if (addr == A_LOOP) begin
      rdata = lp_q;
    end
  end
endmodule

module dma_regbank_chk #(
  parameter int NCH = 16,
  parameter int AW  = 12,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [AW-1:0]  addr,
  input logic [DW-1:0]  wdata,
  input logic [NCH-1:0] done_evt,
  input logic           irq,
  input logic [NCH-1:0] ch_start,
  input logic [NCH-1:0] ch_stop,
  input logic [NCH-1:0] ist,
  input logic [NCH-1:0] ien
);
  // R6
  sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt != '0) |=> ((ist & $past(done_evt)) == $past(done_evt)));
  // R6
  sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((ist & $past(ist)) == $past(ist)));
  // R4
  start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_start));
  // R4
  start_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[1:0] == 2'b00 && int'(addr) < NCH * 16 && addr[3:2] == 2'd0)
      |=> ($countones(ch_start) == 1));
  // R5
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == AW'(12'h140)) |=> (ch_stop == '0));
  // R8
  ien_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(12'h14C)) |=> ((ien & $past(wdata[NCH-1:0])) == '0));
  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((ien != '0) && (ist != '0)));
endmodule

bind dma_regbank dma_regbank_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .done_evt(done_evt), .irq(irq), .ch_start(ch_start), .ch_stop(ch_stop),
  .ist(ist_q), .ien(ien_q)
);

// File: tb/dma_regbank_tb.sv
module dma_regbank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;
  localparam int AW  = 12;
  localparam int NV  = 13;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NCH-1:0]  done_evt = '0;
  logic            irq;
  logic [NCH*32-1:0] ch_addr, ch_xlen, ch_ylen, ch_ctrl, ch_pitch;
  logic [NCH-1:0]  ch_start, ch_stop, loop_en;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_regbank #(.NCH(NCH), .AW(AW), .DW(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .done_evt(done_evt), .irq(irq), .ch_addr(ch_addr),
    .ch_xlen(ch_xlen), .ch_ylen(ch_ylen), .ch_ctrl(ch_ctrl), .ch_pitch(ch_pitch),
    .ch_start(ch_start), .ch_stop(ch_stop), .loop_en(loop_en)
  );

  // write address, write data, read address, expected read, requirement
  localparam logic [AW-1:0] T_WA [NV] = '{12'h000, 12'h014, 12'h0F8, 12'h0AC, 12'h100,
    12'h13C, 12'h148, 12'h14C, 12'h150, 12'h15C, 12'h160, 12'h154, 12'h140};
  localparam logic [31:0] T_WD [NV] = '{32'hDEADBEEF, 32'h00000123, 32'h0000BEEF,
    32'h87654321, 32'h00000011, 32'h00000022, 32'h0000F00F, 32'h0000000F,
    32'hFFFF0003, 32'h00010001, 32'hFFFFFFFF, 32'h00000005, 32'h00000000};
  localparam logic [AW-1:0] T_RA [NV] = '{12'h000, 12'h014, 12'h0F8, 12'h0AC, 12'h100,
    12'h13C, 12'h148, 12'h148, 12'h150, 12'h150, 12'h160, 12'h154, 12'h140};
  localparam logic [31:0] T_EX [NV] = '{32'hDEADBEEF, 32'h00000123, 32'h0000BEEF,
    32'h87654321, 32'h00000011, 32'h00000022, 32'h0000F00F, 32'h0000F000,
    32'hFFFF0003, 32'hFFFE0002, 32'h00000000, 32'h00000000, 32'h00000000};
  // R2 x4, R3 x2, R8 x2, R10 x2, R11 x2, R5
  localparam int T_RQ [NV] = '{2, 2, 2, 2, 3, 3, 8, 8, 10, 10, 11, 11, 5};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    check(tag, rdata, exp);
    addr = '0;
  endtask

  task automatic pulse(input logic [NCH-1:0] d);
    @(negedge clk);
    done_evt = d;
    @(negedge clk);
    done_evt = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(12'h000, 32'h0, "R1 ch0 address");
    rd(12'h144, 32'h0, "R1 status");
    rd(12'h150, 32'h0, "R1 loop word");
    check("R1 irq/start/stop/loop", {28'd0, irq, |ch_start, |ch_stop, |loop_en}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(T_WA[i], T_WD[i]);
      rd(T_RA[i], T_EX[i], $sformatf("R%0d vector %0d", T_RQ[i], i));
    end

    check("R2 ch0 address out", ch_addr[0 +: 32], 32'hDEADBEEF);
    check("R2 ch15 line count out", ch_ylen[15*32 +: 32], 32'h0000BEEF);
    check("R2 ch10 control out", ch_ctrl[10*32 +: 32], 32'h87654321);
    check("R3 ch15 pitch out", ch_pitch[15*32 +: 32], 32'h00000022);
    // R10 only channel 1 has both bit 1 and bit 17 set
    check("R10 loop enables", {16'd0, loop_en}, 32'h00000002);
    wr(12'h15C, 32'hFFFFFFFF);
    check("R10 loop cleared", {16'd0, loop_en}, 32'h0);

    // R4 start strobe
    wr(12'h030, 32'h00001000);
    check("R4 start strobe ch3", {16'd0, ch_start}, 32'h00000008);
    check("R4 ch3 address visible", ch_addr[3*32 +: 32], 32'h00001000);
    @(negedge clk);
    check("R4 start one cycle", {16'd0, ch_start}, 32'h0);
    wr(12'h034, 32'h00000040);
    check("R4 no start on length", {16'd0, ch_start}, 32'h0);

    // R5 stop strobe
    wr(12'h140, 32'h00008001);
    check("R5 stop strobe", {16'd0, ch_stop}, 32'h00008001);
    @(negedge clk);
    check("R5 stop one cycle", {16'd0, ch_stop}, 32'h0);

    // R6 status set and clear, enable is 0xF000 here
    pulse(16'h0003);
    rd(12'h144, 32'h00000003, "R6 status set");
    check("R9 masked irq low", {31'd0, irq}, 32'h0);
    wr(12'h148, 32'h00000002);
    check("R9 enabled irq high", {31'd0, irq}, 32'h1);
    wr(12'h144, 32'h00000002);
    rd(12'h144, 32'h00000001, "R6 write-one clear");
    check("R9 irq low after clear", {31'd0, irq}, 32'h0);
    wr(12'h144, 32'h00000001);
    rd(12'h144, 32'h0, "R6 status empty");

    // R7 event and clear on the same edge
    @(negedge clk);
    done_evt = 16'h0001; wr_en = 1'b1; addr = 12'h144; wdata = 32'h1;
    @(negedge clk);
    done_evt = '0; wr_en = 1'b0; addr = '0; wdata = '0;
    rd(12'h144, 32'h00000001, "R7 event wins over clear");
    wr(12'h144, 32'h00000001);
    rd(12'h144, 32'h0, "R7 later clear");

    // R9 irq timing
    wr(12'h148, 32'h00008000);
    @(negedge clk);
    done_evt = 16'h8000;
    #1;
    check("R9 irq before edge", {31'd0, irq}, 32'h0);
    @(negedge clk);
    done_evt = '0;
    check("R9 irq after edge", {31'd0, irq}, 32'h1);
    rd(12'h14C, 32'h0, "R8 alias reads zero");
    wr(12'h14C, 32'h00008000);
    check("R8 alias clear drops irq", {31'd0, irq}, 32'h0);

    // R11 unmapped and misaligned writes
    wr(12'h200, 32'hFFFFFFFF);
    wr(12'h002, 32'h00000005);
    rd(12'h000, 32'hDEADBEEF, "R11 ch0 untouched");
    rd(12'h002, 32'h0, "R11 misaligned read");
    check("R11 no strobe", {16'd0, ch_start | ch_stop}, 32'h0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule